// File: doc/BRIEF.md
# 8-bit ALU with condition codes

This block is a registered arithmetic and logic unit for an 8-bit datapath. It takes two byte operands, a 5-bit operation select and the current condition-code byte. On a start strobe it registers the result and a new condition-code byte, and it raises a one-cycle valid pulse in the next cycle. The operation set covers the usual accumulator instructions: add and subtract with and without carry, compare, the bitwise operations, load pass-through, the one-operand read-modify-write group (negate, complement, the shifts and rotates, increment, decrement, test, clear), decimal adjust, and an unsigned 8x8 multiply that gives a 16-bit product.

The surrounding core keeps the registers and the memory. It presents the accumulator on `opa`, the memory or immediate operand on `opb` and its flag byte on `cc_in`. It writes back `res_lo` (and `res_hi` for a multiply) and `cc_out`. Operations that only set flags return `opa` unchanged on `res_lo`, so the core can write back without decoding the operation. The condition-code byte keeps a fixed bit layout: carry bit 0, overflow bit 1, zero bit 2, negative bit 3, interrupt mask bit 4, half-carry bit 5, fast-interrupt mask bit 6, entire-state bit 7.

Top module: `alu8_ccr`

## Requirements
- R1: While reset is asserted and until the first start after it, `valid` is 0 and `res_lo`, `res_hi` and `cc_out` are all zero.
- R2: A start sampled on a rising edge produces `valid`=1 after that edge, for one cycle only. With start low, `valid` is 0 and `res_lo`, `res_hi` and `cc_out` hold their values.
- R3: ADD (op 0), ADC (op 1, adds carry bit 0) and ASL (op 15, adds opa to itself) set: C to bit 8 of the 9-bit sum; V to bit 7 of (a^b^sum^(sum>>1)); H (bit 5) to bit 4 of (a^b^sum); N and Z from the 8-bit sum.
- R4: SUB (op 2), SBC (op 3, also subtracts carry bit 0), CMP (op 4) and NEG (op 10, computes 0 minus opa) set C to the borrow in bit 8, and V, N and Z by the rule of R3, and leave H unchanged. CMP returns opa as its result.
- R5: AND (op 5), OR (op 6), EOR (op 7), BIT (op 8, tests opa&opb), LD (op 9, passes opb) and TST (op 19, tests opa) clear V, set N and Z from the value, and leave C and H unchanged. BIT and TST return opa.
- R6: COM (op 11) inverts opa, sets C, clears V and sets N and Z. CLR (op 20) returns 0 with N=0, V=0, Z=1, C=0.
- R7: INC (op 17) sets V exactly when the result is 0x80. DEC (op 18) sets V exactly when the result is 0x7F. Both set N and Z and leave C unchanged.
- R8: LSR (op 12), ROR (op 13) and ASR (op 14) shift right and put old bit 0 in C. LSR fills bit 7 with 0, ROR with the old C, ASR with the old bit 7. ROL (op 16) shifts left with the old C into bit 0 and old bit 7 into C, and sets V to old bit 7 XOR old bit 6. All four set N and Z, and V is unchanged except for ROL.
- R9: DAA (op 21) corrects opa in order: +6 if H; +6 if the low nibble is above 9; +0x60 if C; +0x60 if bits 7:4 are above 9. It sets C when bit 8 of the corrected value is 1 and otherwise leaves C, and it changes no other flag.
- R10: MUL (op 22) returns the unsigned product with the high byte on `res_hi` and the low byte on `res_lo`. It sets Z when the product is zero and C to product bit 7, and leaves the other flags unchanged.
- R11: Every operation passes cc bits 7, 6 and 4 through unchanged. `res_hi` is 0 for every operation except MUL. Opcodes 23 to 31 return opa with the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Captures the operation at this edge |
| op | input | 5 | Operation select |
| opa | input | 8 | Accumulator operand |
| opb | input | 8 | Second operand |
| cc_in | input | 8 | Current condition-code byte |
| valid | output | 1 | One-cycle pulse after a start |
| res_lo | output | 8 | Result, or low product byte |
| res_hi | output | 8 | High product byte, zero otherwise |
| cc_out | output | 8 | Updated condition-code byte |

## Verification
The bench sweeps every opa value under several opb values and four flag bytes. The flag bytes include H and C set alone, together and both clear, so a design that updated H on subtract or on ASR, or that dropped carry-in on ADC or SBC, would show wrong flags on a large share of vectors. The increment and decrement sweeps pass the 0x7F/0x80 boundary, which exposes an overflow taken from the carry chain. The decimal adjust sweep covers all byte values with every H/C pair, so any reordering of the four correction steps, or a carry cleared instead of held, shows up on the vectors where the low-nibble carry feeds the high digit. The multiply sweep catches a carry taken from bit 15 instead of bit 7, and the hold test catches outputs that follow the inputs without a start.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW    = 8;
  localparam int OPW   = 5;
  localparam int CCW   = 8;
  localparam int CC_C  = 0;
  localparam int CC_V  = 1;
  localparam int CC_Z  = 2;
  localparam int CC_N  = 3;
  localparam int CC_H  = 5;
  localparam int NIB   = DW / 2;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_EOR = 5'd7,
    OP_BIT = 5'd8,  OP_LD  = 5'd9,  OP_NEG = 5'd10, OP_COM = 5'd11,
    OP_LSR = 5'd12, OP_ROR = 5'd13, OP_ASR = 5'd14, OP_ASL = 5'd15,
    OP_ROL = 5'd16, OP_INC = 5'd17, OP_DEC = 5'd18, OP_TST = 5'd19,
    OP_CLR = 5'd20, OP_DAA = 5'd21, OP_MUL = 5'd22
  } alu_op_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          c,
  output logic          v,
  output logic          h,
  output logic          n,
  output logic          z
);
  logic [DW:0] sum;
  logic [DW:0] mix;

  always_comb begin
    if (sub) sum = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
    else     sum = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    mix = {1'b0, a} ^ {1'b0, b} ^ sum;
    res = sum[DW-1:0];
    c   = sum[DW];
    v   = mix[DW-1] ^ sum[DW];
    h   = mix[NIB];
    n   = sum[DW-1];
    z   = (sum[DW-1:0] == '0);
  end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  a,
  input  logic [CCW-1:0] cc_in,
  output logic [DW-1:0]  res,
  output logic [CCW-1:0] cc
);
  logic [DW+1:0] adj;
  logic          nz_upd;

  always_comb begin
    res    = a;
    cc     = cc_in;
    nz_upd = 1'b1;
    adj    = {2'b00, a};
    case (op)
      OP_COM: begin res = ~a; cc[CC_C] = 1'b1; cc[CC_V] = 1'b0; end
      OP_LSR: begin res = {1'b0, a[DW-1:1]};        cc[CC_C] = a[0]; end
      OP_ROR: begin res = {cc_in[CC_C], a[DW-1:1]}; cc[CC_C] = a[0]; end
      OP_ASR: begin res = {a[DW-1], a[DW-1:1]};     cc[CC_C] = a[0]; end
      OP_ROL: begin
        res      = {a[DW-2:0], cc_in[CC_C]};
        cc[CC_C] = a[DW-1];
        cc[CC_V] = a[DW-1] ^ a[DW-2];
      end
      OP_INC: begin res = a + 1'b1; cc[CC_V] = (res == {1'b1, {(DW-1){1'b0}}}); end
      OP_DEC: begin res = a - 1'b1; cc[CC_V] = (res == {1'b0, {(DW-1){1'b1}}}); end
      OP_CLR: begin res = '0; cc[CC_C] = 1'b0; cc[CC_V] = 1'b0; end
      OP_DAA: begin
        nz_upd = 1'b0;
        if (cc_in[CC_H])         adj = adj + 10'd6;
        if (adj[NIB-1:0] > 4'd9) adj = adj + 10'd6;
        if (cc_in[CC_C])         adj = adj + 10'h60;
        if (adj[DW-1:NIB] > 4'd9) adj = adj + 10'h60;
        res = adj[DW-1:0];
        if (adj[DW]) cc[CC_C] = 1'b1;
      end
      default: nz_upd = 1'b0;
    endcase
    if (nz_upd) begin
      cc[CC_N] = res[DW-1];
      cc[CC_Z] = (res == '0);
    end
  end
endmodule

// File: rtl/alu8_ccr.sv
module alu8_ccr
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  opa,
  input  logic [DW-1:0]  opb,
  input  logic [CCW-1:0] cc_in,
  output logic           valid,
  output logic [DW-1:0]  res_lo,
  output logic [DW-1:0]  res_hi,
  output logic [CCW-1:0] cc_out
);
  localparam int PW = 2 * DW;

  logic [1:0]     rst_sync;
  logic           rst_q_n;
  logic [DW-1:0]  as_a, as_b, as_res;
  logic           as_cin, as_sub, as_c, as_v, as_h, as_n, as_z;
  logic [DW-1:0]  un_res;
  logic [CCW-1:0] un_cc;
  logic [DW-1:0]  lg_val;
  logic [PW-1:0]  prod;
  logic [DW-1:0]  nxt_lo, nxt_hi;
  logic [CCW-1:0] nxt_cc;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // operand steering for the shared adder
  always_comb begin
    as_a   = opa;
    as_b   = opb;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC:         as_cin = cc_in[CC_C];
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_cin = cc_in[CC_C]; end
      OP_NEG: begin as_sub = 1'b1; as_a = '0; as_b = opa; end
      OP_ASL:         as_b = opa;
      default: ;
    endcase
  end

  alu8_addsub u_addsub (
    .a(as_a), .b(as_b), .cin(as_cin), .sub(as_sub),
    .res(as_res), .c(as_c), .v(as_v), .h(as_h), .n(as_n), .z(as_z)
  );

  alu8_unary u_unary (
    .op(op), .a(opa), .cc_in(cc_in), .res(un_res), .cc(un_cc)
  );

  always_comb begin
    case (op)
      OP_AND, OP_BIT: lg_val = opa & opb;
      OP_OR:          lg_val = opa | opb;
      OP_EOR:         lg_val = opa ^ opb;
      OP_LD:          lg_val = opb;
      default:        lg_val = opa;
    endcase
    prod = opa * opb;
  end

  // next state
  always_comb begin
    nxt_lo = opa;
    nxt_hi = '0;
    nxt_cc = cc_in;
    case (op)
      OP_ADD, OP_ADC, OP_ASL: begin
        nxt_lo = as_res;
        nxt_cc[CC_C] = as_c; nxt_cc[CC_V] = as_v; nxt_cc[CC_H] = as_h;
        nxt_cc[CC_N] = as_n; nxt_cc[CC_Z] = as_z;
      end
      OP_SUB, OP_SBC, OP_NEG, OP_CMP: begin
        if (op != OP_CMP) nxt_lo = as_res;
        nxt_cc[CC_C] = as_c; nxt_cc[CC_V] = as_v;
        nxt_cc[CC_N] = as_n; nxt_cc[CC_Z] = as_z;
      end
      OP_AND, OP_OR, OP_EOR, OP_LD, OP_BIT, OP_TST: begin
        if (op != OP_BIT && op != OP_TST) nxt_lo = lg_val;
        nxt_cc[CC_V] = 1'b0;
        nxt_cc[CC_N] = lg_val[DW-1];
        nxt_cc[CC_Z] = (lg_val == '0);
      end
      OP_COM, OP_LSR, OP_ROR, OP_ASR, OP_ROL,
      OP_INC, OP_DEC, OP_CLR, OP_DAA: begin
        nxt_lo = un_res;
        nxt_cc = un_cc;
      end
      OP_MUL: begin
        {nxt_hi, nxt_lo} = prod;
        nxt_cc[CC_Z] = (prod == '0);
        nxt_cc[CC_C] = prod[DW-1];
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      valid  <= 1'b0;
      res_lo <= '0;
      res_hi <= '0;
      cc_out <= '0;
    end else begin
      valid <= start;
      if (start) begin
        res_lo <= nxt_lo;
        res_hi <= nxt_hi;
        cc_out <= nxt_cc;
      end
    end
  end

  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !start |=> (!valid && $stable(res_lo) && $stable(res_hi) && $stable(cc_out)));
  // R11
  mask_pass_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    start |=> (cc_out[7:6] == $past(cc_in[7:6]) && cc_out[4] == $past(cc_in[4])));
  // R6
  clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && op == OP_CLR) |=> (res_lo == '0 && cc_out[3:0] == 4'b0100));
  // R7
  inc_ovf_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && op == OP_INC) |=> (cc_out[CC_V] == (res_lo == 8'h80) &&
                                 cc_out[CC_C] == $past(cc_in[CC_C])));
  // R10
  mul_zero_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (start && op == OP_MUL) |=> (cc_out[CC_Z] == ({res_hi, res_lo} == '0)));
endmodule

// File: tb/tb_alu8_ccr.sv
`timescale 1ns/1ps
module tb_alu8_ccr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] opa = '0, opb = '0, cc_in = '0;
  logic       valid;
  logic [7:0] res_lo, res_hi, cc_out;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu8_ccr dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
    .cc_in(cc_in), .valid(valid), .res_lo(res_lo), .res_hi(res_hi), .cc_out(cc_out)
  );

  function automatic string req_of(int o);
    case (o)
      0, 1, 15:     return "R3";
      2, 3, 4, 10:  return "R4";
      5, 6, 7, 8, 9, 19: return "R5";
      11, 20:       return "R6";
      17, 18:       return "R7";
      12, 13, 14, 16: return "R8";
      21:           return "R9";
      22:           return "R10";
      default:      return "R11";
    endcase
  endfunction

  function automatic int put(int ccv, int pos, int val);
    return (ccv & ~(1 << pos)) | ((val & 1) << pos);
  endfunction

  function automatic int nz(int ccv, int x);
    int t;
    t = put(ccv, 2, ((x & 255) == 0) ? 1 : 0);
    return put(t, 3, (x >> 7) & 1);
  endfunction

  function automatic logic [23:0] model(int o, int a, int b, int cc);
    int r, res, hi, cf, k, aa, bb, d, p;
    cf = cc & 1; res = a; hi = 0; k = cc;
    case (o)
      0, 1, 15: begin
        bb = (o == 15) ? a : b;
        r = a + bb + ((o == 1) ? cf : 0);
        k = nz(k, r); k = put(k, 0, r >> 8);
        k = put(k, 1, ((a ^ bb ^ r ^ (r >> 1)) >> 7));
        k = put(k, 5, ((a ^ bb ^ r) >> 4));
        res = r & 255;
      end
      2, 3, 4, 10: begin
        aa = (o == 10) ? 0 : a; bb = (o == 10) ? a : b;
        r = (aa - bb - ((o == 3) ? cf : 0)) & 511;
        k = nz(k, r); k = put(k, 0, r >> 8);
        k = put(k, 1, ((aa ^ bb ^ r ^ (r >> 1)) >> 7));
        res = (o == 4) ? a : (r & 255);
      end
      5: begin res = a & b; k = put(nz(k, res), 1, 0); end
      6: begin res = a | b; k = put(nz(k, res), 1, 0); end
      7: begin res = a ^ b; k = put(nz(k, res), 1, 0); end
      8: begin k = put(nz(k, a & b), 1, 0); end
      9: begin res = b; k = put(nz(k, res), 1, 0); end
      19: begin k = put(nz(k, a), 1, 0); end
      11: begin res = (~a) & 255; k = put(put(nz(k, res), 0, 1), 1, 0); end
      12: begin res = a >> 1; k = put(nz(k, res), 0, a); end
      13: begin res = (a >> 1) | (cf << 7); k = put(nz(k, res), 0, a); end
      14: begin res = (a >> 1) | (a & 128); k = put(nz(k, res), 0, a); end
      16: begin
        res = ((a << 1) | cf) & 255;
        k = put(put(nz(k, res), 0, a >> 7), 1, (a >> 7) ^ (a >> 6));
      end
      17: begin res = (a + 1) & 255; k = put(nz(k, res), 1, (res == 128) ? 1 : 0); end
      18: begin res = (a + 255) & 255; k = put(nz(k, res), 1, (res == 127) ? 1 : 0); end
      20: begin res = 0; k = (k & ~15) | 4; end
      21: begin
        d = a;
        if ((cc >> 5) & 1) d = d + 6;
        if ((d & 15) > 9) d = d + 6;
        if (cf == 1) d = d + 96;
        if (((d >> 4) & 15) > 9) d = d + 96;
        res = d & 255;
        if ((d >> 8) & 1) k = k | 1;
      end
      22: begin
        p = a * b; res = p & 255; hi = p >> 8;
        k = put(put(k, 2, (p == 0) ? 1 : 0), 0, p >> 7);
      end
      default: ;
    endcase
    return {8'(k), 8'(hi), 8'(res)};
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // assumes caller sits just after a falling edge; returns one falling edge later
  task automatic run(int o, int a, int b, int cc);
    logic [23:0] exp;
    op = 5'(o); opa = 8'(a); opb = 8'(b); cc_in = 8'(cc); start = 1'b1;
    exp = model(o, a, b, cc);
    @(negedge clk);
    checks++;
    if (!valid || {cc_out, res_hi, res_lo} != exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h cc=%h got v=%b %h exp v=1 %h",
               req_of(o), o, a, b, cc, valid, {cc_out, res_hi, res_lo}, exp);
    end
  endtask

  int bv[8] = '{8'h00, 8'h01, 8'h0F, 8'h10, 8'h7F, 8'h80, 8'hFF, 8'h5A};
  int cv[4] = '{8'h00, 8'hFF, 8'h20, 8'hC1};
  int un_ops[12] = '{10, 11, 12, 13, 14, 15, 16, 17, 18, 19, 20, 21};

  initial begin
    logic [23:0] held;
    repeat (3) @(negedge clk);
    checks++;
    if (valid !== 1'b0 || {cc_out, res_hi, res_lo} !== 24'h0) begin
      errors++; $display("FAIL R1 in reset got %b %h exp 0 000000", valid, {cc_out, res_hi, res_lo});
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (valid !== 1'b0 || {cc_out, res_hi, res_lo} !== 24'h0) begin
      errors++; $display("FAIL R1 after release got %b %h exp 0 000000", valid, {cc_out, res_hi, res_lo});
    end
    // R3 R4 R5: two-operand sweep
    for (int o = 0; o <= 9; o++)
      for (int c = 0; c < 4; c++)
        for (int j = 0; j < 8; j++)
          for (int a = 0; a < 256; a++) run(o, a, bv[j], cv[c]);
    // R6 R7 R8 R9: single-operand sweep
    for (int u = 0; u < 12; u++)
      for (int c = 0; c < 4; c++)
        for (int a = 0; a < 256; a++) run(un_ops[u], a, 8'h3C, cv[c]);
    // R10 multiply
    for (int b = 0; b < 32; b++)
      for (int a = 0; a < 256; a++) run(22, a, (b * 8) | (b >> 2), 8'h5A);
    // R11 unused opcodes
    for (int o = 23; o < 32; o++)
      for (int c = 0; c < 4; c++) run(o, 8'hA5 ^ o, 8'h33, cv[c]);
    // R2 pulse and hold
    run(0, 8'h12, 8'h34, 8'h00);
    held = {cc_out, res_hi, res_lo};
    start = 1'b0; op = 5'd22; opa = 8'hFF; opb = 8'hFF; cc_in = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      checks++;
      if (valid !== 1'b0 || {cc_out, res_hi, res_lo} !== held) begin
        errors++;
        $display("FAIL R2 hold cycle %0d got %b %h exp 0 %h", i, valid, {cc_out, res_hi, res_lo}, held);
      end
    end
    done = 1;
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired got running exp finished");
      summary();
    end
  end
endmodule